// File: doc/BRIEF.md
# Base-Limit Address Relocation and Protection Unit

This unit sits on the address path between a processor and memory. Every access from a user process carries a logical address. The unit checks that address against a limit register and adds a base register to it, which gives the physical address. An access that falls outside the permitted window is never sent to memory. Instead, the unit raises a fault for one cycle and reports the offending logical address. The limit comparison and the base addition are evaluated side by side, so the fault verdict and the relocated address are registered on the same clock edge. The response therefore follows the request by exactly one cycle.

The unit keeps a two-state mode machine. In state `MODE_PRIV` (the reset state), addresses pass straight through, zero-extended, with no limit check, and the configuration port may load the base and limit registers. In state `MODE_USER`, every access is relocated and checked, and any attempt to write the configuration port is rejected and flagged. Software moves the machine between the states with `mode_set`. The transition `PRIV_TO_USER` is taken when `mode_set` is high and `mode_user` is 1. The transition `USER_TO_PRIV` is taken when `mode_set` is high and `mode_user` is 0. In all other cases the machine holds its state. The current register values are visible on the readback outputs, so a context switch can save them and load new ones.

Top module: `bl_mmu_top`

## Requirements
- R1: After reset the unit is in `MODE_PRIV`, both registers read zero, and `mem_valid`, `fault` and `priv_viol` are low.
- R2: In `MODE_USER`, a request whose logical address is strictly greater than the limit produces `fault` high for one cycle on the edge after the request, with `fault_addr` equal to that logical address, and with `mem_valid` low.
- R3: In `MODE_USER`, a logical address equal to the limit is within bounds and is forwarded.
- R4: In `MODE_USER`, an in-bounds request gives `mem_addr` = zero-extended logical address + base, taken modulo 2^PW.
- R5: The fault verdict and the translated address share one pipeline stage, so each request yields exactly one of `mem_valid` or `fault` on the next cycle and neither one cycle later.
- R6: In `MODE_PRIV`, a configuration write with `cfg_sel`=0 loads base from `cfg_wdata`, and with `cfg_sel`=1 loads limit from `cfg_wdata[AW-1:0]`. The new value is visible on the readback outputs from the next cycle.
- R7: In `MODE_USER`, a configuration write leaves both registers unchanged and pulses `priv_viol` high for one cycle on the next edge.
- R8: In `MODE_PRIV`, every request is forwarded with `mem_addr` equal to the zero-extended logical address, whatever the base and limit are, and it never faults.
- R9: Reads (`req_write`=0) and writes (`req_write`=1) are checked the same way. `mem_write` repeats `req_write` for a forwarded access.
- R10: A `mode_set` takes effect from the next cycle. A request presented in the same cycle as `mode_set` is handled under the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_set | input | 1 | Mode change strobe |
| mode_user | input | 1 | Target mode with the strobe: 1 user, 0 privileged |
| req_valid | input | 1 | Access request valid |
| req_write | input | 1 | Access is a write |
| req_addr | input | AW | Logical address |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects base, 1 selects limit |
| cfg_wdata | input | PW | Register write data |
| mem_valid | output | 1 | Forwarded access valid |
| mem_write | output | 1 | Forwarded access is a write |
| mem_addr | output | PW | Physical address |
| fault | output | 1 | Protection fault pulse |
| fault_addr | output | AW | Logical address that faulted |
| priv_viol | output | 1 | Rejected user-mode register write pulse |
| base_out | output | PW | Current base register |
| limit_out | output | AW | Current limit register |

## Verification
The main translation path is exercised in several ways. Addresses are placed just below, exactly at and just above the limit, and at the top of the logical space, which separates a `>` comparison from a `>=` comparison. The same addresses are sent in privileged mode, which shows that the bypass ignores both base and limit. Read and write accesses are mixed to show that the check does not depend on direction. A base close to the top of the physical space forces the sum to wrap. A request issued in the same cycle as a mode change shows which mode governs that request.

// File: rtl/bl_mmu_pkg.sv
package bl_mmu_pkg;
    typedef enum logic {
        MODE_PRIV = 1'b0,
        MODE_USER = 1'b1
    } mmu_mode_e;

    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/bl_mmu_regs.sv
module bl_mmu_regs
    import bl_mmu_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mmu_mode_e     mode,
    input  logic          we,
    input  cfg_sel_e      sel,
    input  logic [PW-1:0] wdata,
    output logic [PW-1:0] base_q,
    output logic [AW-1:0] limit_q,
    output logic          viol_q
);
    logic allowed;

    always_comb begin
        allowed = we && (mode == MODE_PRIV);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
            viol_q  <= 1'b0;
        end else begin
            viol_q <= we && (mode == MODE_USER);
            if (allowed) begin
                unique case (sel)
                    SEL_BASE:  base_q  <= wdata;
                    SEL_LIMIT: limit_q <= wdata[AW-1:0];
                endcase
            end
        end
    end

    AST_USER_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we && mode == MODE_USER) |-> ($stable(base_q) && $stable(limit_q))); // R7
    AST_VIOL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        viol_q |-> $past(we)); // R7
endmodule

// File: rtl/bl_mmu_xlate.sv
module bl_mmu_xlate
    import bl_mmu_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mmu_mode_e     mode,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [PW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [PW-1:0] mem_addr,
    output logic          fault,
    output logic [AW-1:0] fault_addr
);
    localparam int EXT = PW - AW;

    logic [PW-1:0] addr_ext;
    logic [PW-1:0] reloc;
    logic          over;
    logic          is_user;

    // comparison and addition are independent paths, evaluated side by side
    always_comb begin
        addr_ext = {{EXT{1'b0}}, req_addr};
        reloc    = addr_ext + base;
        over     = req_addr > limit;
        is_user  = (mode == MODE_USER);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid  <= 1'b0;
            mem_write  <= 1'b0;
            mem_addr   <= '0;
            fault      <= 1'b0;
            fault_addr <= '0;
        end else begin
            mem_valid  <= req_valid && !(is_user && over);
            mem_write  <= req_valid && req_write;
            mem_addr   <= is_user ? reloc : addr_ext;
            fault      <= req_valid && is_user && over;
            fault_addr <= (req_valid && is_user && over) ? req_addr : '0;
        end
    end

    AST_FAULT_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault && mem_valid)); // R2
    AST_PRIV_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode == MODE_PRIV) |-> !fault); // R8
    AST_AT_LIMIT_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && mode == MODE_USER && req_addr == limit) |-> mem_valid); // R3
    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) |-> $onehot({mem_valid, fault})); // R5
    AST_NO_STRAY_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> !(mem_valid || fault)); // R5
endmodule

// File: rtl/bl_mmu_top.sv
module bl_mmu_top
    import bl_mmu_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_set,
    input  logic          mode_user,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [PW-1:0] cfg_wdata,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [PW-1:0] mem_addr,
    output logic          fault,
    output logic [AW-1:0] fault_addr,
    output logic          priv_viol,
    output logic [PW-1:0] base_out,
    output logic [AW-1:0] limit_out
);
    mmu_mode_e state, state_nx;
    cfg_sel_e  sel_e;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= MODE_PRIV;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            MODE_PRIV: if (mode_set && mode_user)  state_nx = MODE_USER; // PRIV_TO_USER
            MODE_USER: if (mode_set && !mode_user) state_nx = MODE_PRIV; // USER_TO_PRIV
        endcase
        sel_e = cfg_sel_e'(cfg_sel);
    end

    bl_mmu_regs #(.AW(AW), .PW(PW)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (state),
        .we      (cfg_we),
        .sel     (sel_e),
        .wdata   (cfg_wdata),
        .base_q  (base_out),
        .limit_q (limit_out),
        .viol_q  (priv_viol)
    );

    bl_mmu_xlate #(.AW(AW), .PW(PW)) xlate_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (state),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .base       (base_out),
        .limit      (limit_out),
        .mem_valid  (mem_valid),
        .mem_write  (mem_write),
        .mem_addr   (mem_addr),
        .fault      (fault),
        .fault_addr (fault_addr)
    );

    AST_MODE_ENTER_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_set && mode_user) |=> (state == MODE_USER)); // R10
    AST_MODE_ENTER_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_set && !mode_user) |=> (state == MODE_PRIV)); // R10
    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_set |=> $stable(state)); // R10
endmodule

// File: tb/bl_mmu_top_tb_top.sv
module bl_mmu_top_tb_top;
    localparam int AW = 16;
    localparam int PW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_set = 1'b0, mode_user = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [PW-1:0] cfg_wdata = '0;
    logic          mem_valid, mem_write, fault, priv_viol;
    logic [PW-1:0] mem_addr, base_out;
    logic [AW-1:0] fault_addr, limit_out;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    bit cur_user = 1'b0;

    always #10 clk = ~clk;

    bl_mmu_top #(.AW(AW), .PW(PW)) dut_i (.*);

    // {user, write, addr}
    localparam int NV = 10;
    localparam logic [17:0] VEC [0:NV-1] = '{
        {1'b1, 1'b0, 16'h0000},
        {1'b1, 1'b0, 16'h0FFE},
        {1'b1, 1'b0, 16'h0FFF},
        {1'b1, 1'b0, 16'h1000},
        {1'b1, 1'b1, 16'h0800},
        {1'b1, 1'b1, 16'h2000},
        {1'b1, 1'b0, 16'hFFFF},
        {1'b0, 1'b0, 16'hFFFF},
        {1'b0, 1'b1, 16'h1234},
        {1'b1, 1'b1, 16'h0123}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input bit u);
        @(negedge clk); mode_set = 1'b1; mode_user = u;
        @(negedge clk); mode_set = 1'b0;
        cur_user = u;
    endtask

    task automatic cfg_write(input bit sel, input logic [PW-1:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // issue one request; outputs sampled one negedge later (one register stage)
    task automatic do_req(input bit wr, input logic [AW-1:0] a,
                          input logic [PW-1:0] b, input logic [AW-1:0] l, input string tag);
        logic exp_f;
        logic [PW-1:0] exp_p;
        exp_f = cur_user && (a > l);
        exp_p = cur_user ? ({{(PW-AW){1'b0}}, a} + b) : {{(PW-AW){1'b0}}, a};
        @(negedge clk); req_valid = 1'b1; req_write = wr; req_addr = a;
        @(negedge clk); req_valid = 1'b0;
        chk(fault == exp_f, {tag, " R2 fault"}, 32'(fault), 32'(exp_f));
        chk(mem_valid == !exp_f, {tag, " R5 mem_valid"}, 32'(mem_valid), 32'(!exp_f));
        if (exp_f) chk(fault_addr == a, {tag, " R2 fault_addr"}, 32'(fault_addr), 32'(a));
        else begin
            chk(mem_addr == exp_p, {tag, " R4 mem_addr"}, 32'(mem_addr), 32'(exp_p));
            chk(mem_write == wr, {tag, " R9 mem_write"}, 32'(mem_write), 32'(wr));
        end
        @(negedge clk);
        chk(!fault && !mem_valid, {tag, " R5 single pulse"}, 32'({fault, mem_valid}), 32'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(base_out == 0 && limit_out == 0, "R1 regs zero", 32'(base_out), 32'(0));
        chk(!mem_valid && !fault && !priv_viol, "R1 outputs idle", 32'({mem_valid, fault, priv_viol}), 32'(0));
        // R1/R8: privileged at reset, limit 0 does not fault
        do_req(1'b0, 16'h8000, 20'h0, 16'h0, "R1 R8 priv after reset");

        // R6 configuration
        cfg_write(1'b0, 20'h0F000);
        chk(base_out == 20'h0F000, "R6 base load", 32'(base_out), 32'h0F000);
        cfg_write(1'b1, 20'hA0FFF);
        chk(limit_out == 16'h0FFF, "R6 limit load", 32'(limit_out), 32'h0FFF);

        // table walk (R2 R3 R4 R8 R9)
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][17] != cur_user) set_mode(VEC[i][17]);
            do_req(VEC[i][16], VEC[i][15:0], 20'h0F000, 16'h0FFF, $sformatf("vec%0d", i));
        end

        // R7 user write rejected (unit is in user mode after table)
        @(negedge clk); cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 20'h12345;
        @(negedge clk); cfg_we = 1'b0;
        chk(priv_viol == 1'b1, "R7 viol flag", 32'(priv_viol), 32'(1));
        chk(base_out == 20'h0F000, "R7 base kept", 32'(base_out), 32'h0F000);
        @(negedge clk);
        chk(priv_viol == 1'b0, "R7 viol pulse", 32'(priv_viol), 32'(0));
        @(negedge clk); cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 20'h00001;
        @(negedge clk); cfg_we = 1'b0;
        chk(limit_out == 16'h0FFF, "R7 limit kept", 32'(limit_out), 32'h0FFF);

        // R10: request alongside a mode change uses old mode (user -> priv)
        @(negedge clk); mode_set = 1'b1; mode_user = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'hFFFF;
        @(negedge clk); mode_set = 1'b0; req_valid = 1'b0;
        chk(fault == 1'b1, "R10 old mode user", 32'(fault), 32'(1));
        cur_user = 1'b0;
        do_req(1'b0, 16'hFFFF, 20'h0F000, 16'h0FFF, "R10 new mode priv");

        // R10: priv -> user with simultaneous request: no fault
        @(negedge clk); mode_set = 1'b1; mode_user = 1'b1;
        req_valid = 1'b1; req_addr = 16'hFFFF;
        @(negedge clk); mode_set = 1'b0; req_valid = 1'b0;
        chk(mem_valid && !fault, "R10 old mode priv", 32'({mem_valid, fault}), 32'(2));
        chk(mem_addr == 20'h0FFFF, "R10 untranslated", 32'(mem_addr), 32'h0FFFF);
        cur_user = 1'b1;

        // R4 wrap-around
        set_mode(1'b0);
        cfg_write(1'b0, 20'hFFFF0);
        cfg_write(1'b1, 20'h0FFFF);
        set_mode(1'b1);
        do_req(1'b0, 16'h0020, 20'hFFFF0, 16'hFFFF, "R4 wrap");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule